// File: doc/BRIEF.md
# Cartridge Bank Mapper with Clock Register Window

This block sits between a CPU with a 16-bit address bus and the memories on a plug-in cartridge. It turns CPU reads below 0x8000 into linear ROM addresses. The lower 16 KiB region is fixed. The upper 16 KiB region shows one of up to 128 switchable banks. The 8 KiB window at 0xA000–0xBFFF can be mapped to one of four external RAM banks, or to one of five timekeeping registers: seconds, minutes, hours, day-low and day-high.

Control registers are loaded by CPU writes into the ROM address space. Four 8 KiB ranges each hold one register:
- 0x0000–0x1FFF: access enable.
- 0x2000–0x3FFF: ROM bank.
- 0x4000–0x5FFF: window mapping.
- 0x6000–0x7FFF: latch sequence.

A 0x00 write followed by a 0x01 write to the latch range produces a one-cycle latch pulse. The external clock block uses this pulse to copy its live counter into a snapshot.

The external clock block owns the live counter and the snapshot:
- A clock register read strobe asks that block for the snapshot value.
- A clock register write strobe targets the live counter.

The address outputs and strobes are combinational from the CPU bus and the registered state. A CPU access is a single-cycle strobe. There is no back-pressure. `cpu_rd` and `cpu_wr` are never asserted together.

Top module: `cart_mapper`

## Requirements
- R1: After reset, access is disabled, the ROM bank is 1, the RAM bank is 0, and the window maps nothing. A read at 0x4000 gives ROM address 0x4000, and a read of the window raises `open_rd`.
- R2: A read at 0x0000–0x3FFF raises `rom_rd` with `rom_addr` equal to the CPU address, whatever bank is selected.
- R3: A write to 0x2000–0x3FFF loads the ROM bank from data bits [6:0]. A read at 0x4000–0x7FFF raises `rom_rd` with `rom_addr` = bank × 0x4000 + (address − 0x4000).
- R4: Writing bank number 0 to 0x2000–0x3FFF selects bank 1.
- R5: A write to 0x0000–0x1FFF whose low four data bits equal 0xA enables window access. Any other value disables it. While disabled, no RAM or clock strobe is raised.
- R6: Writing 0x00–0x03 to 0x4000–0x5FFF does two things. It sets the RAM bank to data bits [1:0], and it maps RAM into the window. Window accesses then raise `ram_rd` or `ram_we` with `ram_addr` = bank × 0x2000 + (address − 0xA000).
- R7: Writing 0x08–0x0C to 0x4000–0x5FFF maps a clock register into the window. The `rtc_sel` codes are seconds 0, minutes 1, hours 2, day-low 3, day-high 4. A window read raises `rtc_rd` and a window write raises `rtc_we`.
- R8: Writing any other value to 0x4000–0x5FFF leaves both the mapping and the RAM bank unchanged.
- R9: A window read while disabled or unmapped raises `open_rd`, meaning the CPU sees 0xFF. A window write in that state raises no strobe.
- R10: `rtc_latch` is high during a write of 0x01 to 0x6000–0x7FFF when the previous write to that range was 0x00, and only then. Writes to other ranges do not break the sequence.
- R11: At most one of `rom_rd`, `ram_rd`, `ram_we`, `rtc_rd`, `rtc_we` and `open_rd` is high at a time. Accesses at 0x8000–0x9FFF and 0xC000–0xFFFF raise none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| rom_addr | output | ROM_BANK_W+14 | Linear ROM address |
| rom_rd | output | 1 | ROM read strobe |
| ram_addr | output | RAM_BANK_W+13 | Linear external RAM address |
| ram_rd | output | 1 | External RAM read strobe |
| ram_we | output | 1 | External RAM write enable |
| rtc_sel | output | 3 | Clock register select (0 seconds … 4 day-high) |
| rtc_rd | output | 1 | Read of the snapshot register chosen by `rtc_sel` |
| rtc_we | output | 1 | Write of the live register chosen by `rtc_sel`; data is `cpu_wdata` |
| rtc_latch | output | 1 | Snapshot request pulse |
| open_rd | output | 1 | Window read with nothing behind it; CPU sees 0xFF |

## Verification
The bench builds the block with its default widths: a 7-bit ROM bank and a 2-bit RAM bank. With these widths, bank 127 and RAM bank 3 can be exercised. The bench checks the top ROM address 0x1FFFFF and the top RAM address 0x7FFF, the bank-0 substitution, and every clock register code. The latch sequence is checked with other writes placed between its two steps, with a repeated 0x01 write, and with a first write issued straight after reset.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

  // What the 0xA000 window currently shows; clock entries follow register order.
  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_RAM  = 3'd1,
    WIN_SEC  = 3'd2,
    WIN_MIN  = 3'd3,
    WIN_HR   = 3'd4,
    WIN_DLO  = 3'd5,
    WIN_DHI  = 3'd6
  } win_map_e;

  // Upper three address bits of each 8 KiB range
  localparam logic [2:0] RG_ENABLE = 3'b000;
  localparam logic [2:0] RG_ROMBNK = 3'b001;
  localparam logic [2:0] RG_WINSEL = 3'b010;
  localparam logic [2:0] RG_LATCH  = 3'b011;
  localparam logic [2:0] RG_WINDOW = 3'b101;

  localparam logic [7:0] CLK_CODE_LO = 8'h08;
  localparam logic [7:0] CLK_CODE_HI = 8'h0C;
  localparam logic [3:0] ENABLE_KEY  = 4'hA;

endpackage

// File: rtl/cmap_ctrl.sv
module cmap_ctrl
  import cmap_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [2:0]            addr_hi,
  input  logic [7:0]            wdata,
  output logic                  acc_en,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output win_map_e              win_map
);
  localparam int RAM_BANKS = 1 << RAM_BANK_W;

  logic [ROM_BANK_W-1:0] bank_req;
  logic                  ram_code, clk_code;
  win_map_e              clk_map;

  assign bank_req = wdata[ROM_BANK_W-1:0];
  assign ram_code = wdata < 8'(RAM_BANKS);
  assign clk_code = (wdata >= CLK_CODE_LO) && (wdata <= CLK_CODE_HI);
  assign clk_map  = win_map_e'(3'(wdata[2:0] + 3'd2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_en   <= 1'b0;
      rom_bank <= ROM_BANK_W'(1);
      ram_bank <= '0;
      win_map  <= WIN_NONE;
    end else if (wr) begin
      case (addr_hi)
        RG_ENABLE: acc_en <= (wdata[3:0] == ENABLE_KEY);
        RG_ROMBNK: rom_bank <= (bank_req == '0) ? ROM_BANK_W'(1) : bank_req;
        RG_WINSEL: begin
          if (ram_code) begin
            ram_bank <= wdata[RAM_BANK_W-1:0];
            win_map  <= WIN_RAM;
          end else if (clk_code) begin
            win_map  <= clk_map;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmap_latch.sv
module cmap_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lat_wr,
  input  logic [7:0] wdata,
  output logic       pulse
);
  logic prev_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)      prev_zero <= 1'b0;
    else if (lat_wr) prev_zero <= (wdata == 8'h00);
  end

  assign pulse = lat_wr && prev_zero && (wdata == 8'h01);
endmodule

// File: rtl/cmap_xlate.sv
module cmap_xlate
  import cmap_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW    = ROM_BANK_W + 14,
  localparam int RAM_AW    = RAM_BANK_W + 13
) (
  input  logic [15:0]           addr,
  input  logic                  rd,
  input  logic                  wr,
  input  logic                  acc_en,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  win_map_e              win_map,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_rd,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_rd,
  output logic                  ram_we,
  output logic [2:0]            rtc_sel,
  output logic                  rtc_rd,
  output logic                  rtc_we,
  output logic                  open_rd
);
  logic in_win, ram_acc, clk_acc, clk_mapped;

  assign clk_mapped = (win_map >= WIN_SEC) && (win_map <= WIN_DHI);
  assign in_win     = (addr[15:13] == RG_WINDOW);
  assign ram_acc    = in_win && acc_en && (win_map == WIN_RAM);
  assign clk_acc    = in_win && acc_en && clk_mapped;

  always_comb begin
    rom_rd   = rd && !addr[15];
    rom_addr = addr[14] ? {rom_bank, addr[13:0]} : {{ROM_BANK_W{1'b0}}, addr[13:0]};
  end

  assign ram_addr = {ram_bank, addr[12:0]};
  assign ram_rd   = rd && ram_acc;
  assign ram_we   = wr && ram_acc;
  assign rtc_sel  = clk_mapped ? 3'(win_map - WIN_SEC) : 3'd0;
  assign rtc_rd   = rd && clk_acc;
  assign rtc_we   = wr && clk_acc;
  assign open_rd  = rd && in_win && !(ram_acc || clk_acc);
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cmap_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW    = ROM_BANK_W + 14,
  localparam int RAM_AW    = RAM_BANK_W + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_we,
  output logic [2:0]        rtc_sel,
  output logic              rtc_rd,
  output logic              rtc_we,
  output logic              rtc_latch,
  output logic              open_rd
);
  logic                  acc_en;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  win_map_e              win_map;
  logic                  ctl_wr, lat_wr;

  assign ctl_wr = cpu_wr && !cpu_addr[15];
  assign lat_wr = cpu_wr && (cpu_addr[15:13] == RG_LATCH);

  cmap_ctrl #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .addr_hi  (cpu_addr[15:13]),
    .wdata    (cpu_wdata),
    .acc_en   (acc_en),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .win_map  (win_map)
  );

  cmap_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .lat_wr (lat_wr),
    .wdata  (cpu_wdata),
    .pulse  (rtc_latch)
  );

  cmap_xlate #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_xlate (
    .addr     (cpu_addr),
    .rd       (cpu_rd),
    .wr       (cpu_wr),
    .acc_en   (acc_en),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .win_map  (win_map),
    .rom_addr (rom_addr),
    .rom_rd   (rom_rd),
    .ram_addr (ram_addr),
    .ram_rd   (ram_rd),
    .ram_we   (ram_we),
    .rtc_sel  (rtc_sel),
    .rtc_rd   (rtc_rd),
    .rtc_we   (rtc_we),
    .open_rd  (open_rd)
  );
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk #(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW    = ROM_BANK_W + 14,
  localparam int RAM_AW    = RAM_BANK_W + 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_rd,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_rd,
  input logic              ram_we,
  input logic [2:0]        rtc_sel,
  input logic              rtc_rd,
  input logic              rtc_we,
  input logic              rtc_latch,
  input logic              open_rd
);
  assert_fixed_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:14] == 2'b00) |-> (rom_rd && rom_addr == ROM_AW'(cpu_addr[13:0])));

  assert_bank_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:14] == 2'b01) |-> (rom_addr[ROM_AW-1:14] != '0));

  assert_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA)
      |=> !(ram_rd || ram_we || rtc_rd || rtc_we));

  assert_ram_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || ram_we) |-> (ram_addr[12:0] == cpu_addr[12:0] && cpu_addr[15:13] == 3'b101));

  assert_clk_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_rd || rtc_we) |-> (rtc_sel <= 3'd4));

  assert_latch_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_latch |-> (cpu_wr && cpu_addr[15:13] == 3'b011 && cpu_wdata == 8'h01));

  assert_latch_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_latch |=> !rtc_latch);

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && cpu_wr) |-> $onehot0({rom_rd, ram_rd, ram_we, rtc_rd, rtc_we, open_rd}));
endmodule

bind cart_mapper cart_mapper_chk #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_rd(rom_rd),
  .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_we(ram_we), .rtc_sel(rtc_sel),
  .rtc_rd(rtc_rd), .rtc_we(rtc_we), .rtc_latch(rtc_latch), .open_rd(open_rd)
);

// File: tb/sim_cart_mapper.sv
module sim_cart_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [20:0] rom_addr;
  logic        rom_rd;
  logic [14:0] ram_addr;
  logic        ram_rd, ram_we;
  logic [2:0]  rtc_sel;
  logic        rtc_rd, rtc_we, rtc_latch, open_rd;

  int checks = 0;
  int fails  = 0;
  logic lat_seen;

  always #4 clk = ~clk;

  cart_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_rd(rom_rd),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_we(ram_we), .rtc_sel(rtc_sel),
    .rtc_rd(rtc_rd), .rtc_we(rtc_we), .rtc_latch(rtc_latch), .open_rd(open_rd)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Write on one clock edge; latch pulse sampled while the write is presented.
  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1 lat_seen = rtc_latch;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
  endtask

  task automatic idle();
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic t_reset();
    rd(16'h4000);
    chk("R1 rom_rd", 32'(rom_rd), 1);
    chk("R1 rom_addr bank1", 32'(rom_addr), 32'h4000);
    rd(16'hA000);
    chk("R1 open_rd window", 32'(open_rd), 1);
    chk("R1 no ram_rd", 32'(ram_rd), 0);
    idle();
  endtask

  task automatic t_fixed();
    wr(16'h2000, 8'h05);
    rd(16'h3ABC);
    chk("R2 fixed addr", 32'(rom_addr), 32'h3ABC);
    chk("R2 rom_rd", 32'(rom_rd), 1);
    idle();
  endtask

  task automatic t_switch();
    rd(16'h4123);
    chk("R3 bank5", 32'(rom_addr), 32'h14123);
    wr(16'h3FFF, 8'hFF);
    rd(16'h7FFF);
    chk("R3 bank127 top", 32'(rom_addr), 32'h1FFFFF);
    idle();
  endtask

  task automatic t_bank_zero();
    wr(16'h2100, 8'h00);
    rd(16'h4000);
    chk("R4 zero->bank1", 32'(rom_addr), 32'h4000);
    wr(16'h2000, 8'h80);
    rd(16'h5001);
    chk("R4 0x80->bank1", 32'(rom_addr), 32'h5001);
    idle();
  endtask

  task automatic t_enable_ram();
    wr(16'h4000, 8'h03);
    wr(16'h0000, 8'h1A);
    rd(16'hBFFF);
    chk("R5 enabled by low nibble", 32'(ram_rd), 1);
    chk("R6 ram addr bank3", 32'(ram_addr), 32'h7FFF);
    idle();
    wr(16'h5FFF, 8'h02);
    @(negedge clk);
    cpu_addr = 16'hA010; cpu_wdata = 8'h55; cpu_wr = 1'b1;
    #1;
    chk("R6 ram_we", 32'(ram_we), 1);
    chk("R6 ram addr bank2", 32'(ram_addr), 32'h4010);
    idle();
    wr(16'h1FFF, 8'h0B);
    rd(16'hA010);
    chk("R5 disabled no ram_rd", 32'(ram_rd), 0);
    chk("R9 disabled open_rd", 32'(open_rd), 1);
    idle();
    @(negedge clk);
    cpu_addr = 16'hA010; cpu_wr = 1'b1;
    #1;
    chk("R9 disabled no ram_we", 32'(ram_we), 0);
    idle();
  endtask

  task automatic t_ignore();
    wr(16'h0000, 8'h0A);
    wr(16'h4000, 8'h01);
    wr(16'h4000, 8'h05);
    wr(16'h4000, 8'h0D);
    wr(16'h4000, 8'h07);
    rd(16'hA004);
    chk("R8 still ram", 32'(ram_rd), 1);
    chk("R8 bank kept", 32'(ram_addr), 32'h2004);
    idle();
  endtask

  task automatic t_clock();
    for (int k = 0; k < 5; k++) begin
      wr(16'h4000, 8'(8 + k));
      rd(16'hA000);
      chk("R7 rtc_rd", 32'(rtc_rd), 1);
      chk("R7 rtc_sel", 32'(rtc_sel), 32'(k));
      chk("R7 no ram_rd", 32'(ram_rd), 0);
      idle();
    end
    wr(16'h4000, 8'h0F);
    @(negedge clk);
    cpu_addr = 16'hB000; cpu_wdata = 8'h12; cpu_wr = 1'b1;
    #1;
    chk("R8 clock kept", 32'(rtc_sel), 4);
    chk("R7 rtc_we", 32'(rtc_we), 1);
    idle();
  endtask

  task automatic t_unused();
    rd(16'h8000);
    chk("R11 0x8000 none", 32'({rom_rd, ram_rd, rtc_rd, open_rd}), 0);
    rd(16'hC000);
    chk("R11 0xC000 none", 32'({rom_rd, ram_rd, rtc_rd, open_rd}), 0);
    idle();
  endtask

  task automatic t_latch();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    wr(16'h6000, 8'h01);
    chk("R10 first write no pulse", 32'(lat_seen), 0);
    wr(16'h6000, 8'h00);
    chk("R10 zero no pulse", 32'(lat_seen), 0);
    wr(16'h6000, 8'h01);
    chk("R10 pulse", 32'(lat_seen), 1);
    wr(16'h6000, 8'h01);
    chk("R10 repeat no pulse", 32'(lat_seen), 0);
    wr(16'h7FFF, 8'h00);
    wr(16'h2000, 8'h03);
    wr(16'h7FFF, 8'h01);
    chk("R10 other range between", 32'(lat_seen), 1);
    wr(16'h6000, 8'h00);
    wr(16'h6000, 8'h05);
    wr(16'h6000, 8'h01);
    chk("R10 broken sequence", 32'(lat_seen), 0);
    rd(16'hA000);
    chk("R1 reset unmapped", 32'(open_rd), 1);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_switch();
    t_bank_zero();
    t_enable_ram();
    t_ignore();
    t_clock();
    t_unused();
    t_latch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule